// File: doc/BRIEF.md
# Clock-Enable Timing Scaler

This block derives a full timing hierarchy from one fast reference clock, entirely with clock enables inside a single clock domain. A free-running two-bit index walks four non-overlapping phase signals, one per reference cycle. A master strobe marks the last phase, so it fires once every four reference cycles. A five-position one-hot ring advances on each master strobe and emits a base pulse each time it wraps. That pulse feeds a ripple of binary halving stages.

Each halving stage exposes two outputs. The first is a 50% duty level. The second is a one-cycle strobe that marks the end of that stage's period. One configurable stage raises a sticky request to increment a real-time counter, which stays up until a consumer acknowledges it. A deeper configurable stage produces a wake pulse, but only while the standby flag is set. Downstream logic uses the strobes as enables and never as clocks.

Top module: `timing_scaler`

## Requirements
- R1: While rst_ni is low, phase_o is 4'b0001 and master_stb_o, stage_lvl_o, stage_stb_o, inc_req_o and wake_o are all zero. The ring counter rests at its first position.
- R2: Counting the reference cycle after reset release as t=0, phase_o holds exactly one set bit, at bit position t mod 4.
- R3: master_stb_o is high exactly in the cycles where phase_o[3] is high, which gives one pulse every four cycles.
- R4: The divide-by-five stage is a one-hot ring that moves only on master strobes. It returns to a single hot bit if its state is ever illegal. Its wrap pulse falls in cycles with t mod 20 = 19, so stage 1 changes level every 20 cycles.
- R5: For stage k (bit k-1 of stage_lvl_o), the level equals bit k-1 of floor(t/20). This is a 50% duty square wave with a period of 40·2^(k-1) cycles. NUM_STAGES defaults to 17.
- R6: stage_stb_o[k-1] is high for one cycle exactly when t mod 20 = 19 and floor(t/20)+1 is a multiple of 2^k. That is the last cycle before stage k's level returns to 0.
- R7: inc_req_o is set in the cycle after stage INC_TAP (default 10) strobes. It then stays high until a cycle in which inc_ack_i is high. A strobe in the same cycle as an acknowledge keeps the request set.
- R8: wake_o pulses for one cycle, in the cycle after stage WAKE_TAP (default 17) strobes, and only if standby_i was high in the strobe cycle. Otherwise it stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| standby_i | input | 1 | Standby mode flag that gates the wake pulse |
| inc_ack_i | input | 1 | Acknowledge that clears the increment request |
| phase_o | output | 4 | Non-overlapping rotating phase enables |
| master_stb_o | output | 1 | Master-frequency strobe, one cycle in four |
| stage_lvl_o | output | NUM_STAGES | 50% duty level of each halving stage |
| stage_stb_o | output | NUM_STAGES | End-of-period strobe of each halving stage |
| inc_req_o | output | 1 | Sticky counter-increment request |
| wake_o | output | 1 | Standby wake pulse |

## Verification
The deepest tap is the hardest event to reach, because with the default depth it fires only once in millions of cycles. The bench therefore shortens the chain through its parameters so that wake strobes occur twice within the run. Around those strobes, standby is forced high at one and low at the other. An acknowledge is placed in the same cycle as an increment strobe to exercise the set-wins case. The illegal ring state cannot be driven from the ports, so an in-module assertion covers it.

// File: rtl/scaler_pkg.sv
package scaler_pkg;
  localparam int unsigned PHASES = 4;
  localparam int unsigned PH_W   = $clog2(PHASES);
  typedef logic [PH_W-1:0] phase_idx_t;
endpackage

// File: rtl/scaler_phase_gen.sv
module scaler_phase_gen
  import scaler_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  output logic [PHASES-1:0] phase_o,
  output logic              master_stb_o
);
  phase_idx_t idx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) idx_q <= '0;
    else         idx_q <= idx_q + 1'b1;
  end

  always_comb begin
    phase_o          = '0;
    phase_o[idx_q]   = 1'b1;
  end

  assign master_stb_o = phase_o[PHASES-1];

  assert_phase_wrap_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    phase_o[PHASES-1] |=> phase_o[0]);

  for (genvar g = 0; g < PHASES-1; g++) begin : g_rot
    assert_phase_rotate_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      phase_o[g] |=> phase_o[g+1]);
  end
endmodule

// File: rtl/scaler_ring_div.sv
module scaler_ring_div #(
  parameter int unsigned RING_LEN = 5
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic adv_i,
  output logic wrap_o
);
  localparam logic [RING_LEN-1:0] FIRST = RING_LEN'(1);

  logic [RING_LEN-1:0] ring_q;
  logic                legal;

  assign legal  = (ring_q != '0) && ((ring_q & (ring_q - 1'b1)) == '0);
  assign wrap_o = adv_i & legal & ring_q[RING_LEN-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     ring_q <= FIRST;
    else if (!legal) ring_q <= FIRST;   // self-correct
    else if (adv_i)  ring_q <= {ring_q[RING_LEN-2:0], ring_q[RING_LEN-1]};
  end

  assert_ring_onehot_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot(ring_q));
  assert_ring_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !adv_i |=> $stable(ring_q));
endmodule

// File: rtl/scaler_bin_chain.sv
module scaler_bin_chain #(
  parameter int unsigned NUM_STAGES = 17
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  en_i,
  output logic [NUM_STAGES-1:0] lvl_o,
  output logic [NUM_STAGES-1:0] stb_o
);
  logic [NUM_STAGES:0]   carry;
  logic [NUM_STAGES-1:0] lvl_q;

  assign carry[0] = en_i;

  for (genvar g = 0; g < NUM_STAGES; g++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       lvl_q[g] <= 1'b0;
      else if (carry[g]) lvl_q[g] <= ~lvl_q[g];
    end
    assign carry[g+1] = carry[g] & lvl_q[g];
    assign stb_o[g]   = carry[g+1];

    assert_stage_toggle_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      carry[g] |=> (lvl_q[g] != $past(lvl_q[g])));
    assert_stage_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !carry[g] |=> $stable(lvl_q[g]));
    assert_stage_stb_fall_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      stb_o[g] |=> !lvl_q[g]);
  end

  assign lvl_o = lvl_q;
endmodule

// File: rtl/timing_scaler.sv
module timing_scaler
  import scaler_pkg::*;
#(
  parameter int unsigned NUM_STAGES = 17,
  parameter int unsigned RING_LEN   = 5,
  parameter int unsigned INC_TAP    = 10,
  parameter int unsigned WAKE_TAP   = 17
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  standby_i,
  input  logic                  inc_ack_i,
  output logic [PHASES-1:0]     phase_o,
  output logic                  master_stb_o,
  output logic [NUM_STAGES-1:0] stage_lvl_o,
  output logic [NUM_STAGES-1:0] stage_stb_o,
  output logic                  inc_req_o,
  output logic                  wake_o
);
  localparam int unsigned INC_IDX  = INC_TAP - 1;
  localparam int unsigned WAKE_IDX = WAKE_TAP - 1;

  logic base_stb;
  logic inc_req_q, wake_q;

  scaler_phase_gen u_phase (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .phase_o      (phase_o),
    .master_stb_o (master_stb_o)
  );

  scaler_ring_div #(.RING_LEN(RING_LEN)) u_ring (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .adv_i  (master_stb_o),
    .wrap_o (base_stb)
  );

  scaler_bin_chain #(.NUM_STAGES(NUM_STAGES)) u_chain (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (base_stb),
    .lvl_o  (stage_lvl_o),
    .stb_o  (stage_stb_o)
  );

  // set wins over ack so no tick is lost
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      inc_req_q <= 1'b0;
      wake_q    <= 1'b0;
    end else begin
      inc_req_q <= stage_stb_o[INC_IDX] | (inc_req_q & ~inc_ack_i);
      wake_q    <= stage_stb_o[WAKE_IDX] & standby_i;
    end
  end

  assign inc_req_o = inc_req_q;
  assign wake_o    = wake_q;

  assert_master_phase_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    master_stb_o |=> phase_o[0]);
  assert_req_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inc_req_o && !inc_ack_i) |=> inc_req_o);
  assert_req_set_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stage_stb_o[INC_IDX] |=> inc_req_o);
  assert_wake_gate_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wake_o |-> ($past(standby_i) && $past(stage_stb_o[WAKE_IDX])));
  assert_wake_pulse_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wake_o |=> !wake_o);
endmodule

// File: tb/timing_scaler_test.sv
`timescale 1ns/1ps
module timing_scaler_test;
  localparam int N    = 10;
  localparam int INC  = 3;
  localparam int WAKE = 10;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic standby_i = 1'b0;
  logic inc_ack_i = 1'b0;
  logic [3:0]   phase_o;
  logic         master_stb_o;
  logic [N-1:0] stage_lvl_o, stage_stb_o;
  logic         inc_req_o, wake_o;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #5 clk_i = ~clk_i;

  timing_scaler #(.NUM_STAGES(N), .RING_LEN(5), .INC_TAP(INC), .WAKE_TAP(WAKE)) uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .standby_i(standby_i), .inc_ack_i(inc_ack_i),
    .phase_o(phase_o), .master_stb_o(master_stb_o), .stage_lvl_o(stage_lvl_o),
    .stage_stb_o(stage_stb_o), .inc_req_o(inc_req_o), .wake_o(wake_o)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s at %0t: actual %0h expected %0h", req, $time, act, exp);
    end
  endtask

  function automatic logic [3:0] exp_phase(int t);
    return 4'b0001 << (t % 4);
  endfunction

  function automatic logic [N-1:0] exp_lvl(int t);
    return N'(t / 20);
  endfunction

  function automatic logic [N-1:0] exp_stb(int t);
    logic [N-1:0] v;
    for (int k = 0; k < N; k++)
      v[k] = (t % 20 == 19) && (((t / 20) + 1) % (1 << (k + 1)) == 0);
    return v;
  endfunction

  task automatic chk_reset();
    chk("R1 phase", 32'(phase_o), 32'h1);
    chk("R1 master", 32'(master_stb_o), 0);
    chk("R1 lvl", 32'(stage_lvl_o), 0);
    chk("R1 stb", 32'(stage_stb_o), 0);
    chk("R1 inc_req", 32'(inc_req_o), 0);
    chk("R1 wake", 32'(wake_o), 0);
  endtask

  task automatic run(int cycles);
    logic exp_req = 1'b0, exp_wake = 1'b0;
    logic [N-1:0] s;
    for (int t = 0; t < cycles; t++) begin
      s = exp_stb(t);
      chk("R2 phase", 32'(phase_o), 32'(exp_phase(t)));
      chk("R3 master", 32'(master_stb_o), 32'(t % 4 == 3));
      chk("R4 stage1 level", 32'(stage_lvl_o[0]), 32'((t / 20) % 2));
      chk("R5 levels", 32'(stage_lvl_o), 32'(exp_lvl(t)));
      chk("R6 strobes", 32'(stage_stb_o), 32'(s));
      chk("R7 inc_req", 32'(inc_req_o), 32'(exp_req));
      chk("R8 wake", 32'(wake_o), 32'(exp_wake));
      // stimulus for this cycle
      if (t < 25000)           standby_i = 1'b1;
      else if (t == 40959)     standby_i = 1'b0;
      else                     standby_i = 1'($urandom % 2);
      if (t == 159 || t == 319) inc_ack_i = 1'b1;   // ack together with strobe
      else                      inc_ack_i = ($urandom % 8) == 0;
      exp_req  = s[INC-1] | (exp_req & ~inc_ack_i);
      exp_wake = s[WAKE-1] & standby_i;
      @(negedge clk_i);
    end
  endtask

  initial begin
    void'($urandom(32'd41));
    repeat (3) @(negedge clk_i);
    chk_reset();
    rst_ni = 1'b1;
    run(45000);
    rst_ni = 1'b0;
    standby_i = 1'b0;
    inc_ack_i = 1'b0;
    @(negedge clk_i);
    chk_reset();
    rst_ni = 1'b1;
    run(1000);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(200000 * 10);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end
endmodule